// File: doc/BRIEF.md
# Star-Wired Control Link Master with Slave Endpoints

This block lets one control device reach several peripheral devices, each over its own three-wire synchronous link carrying a serial clock, a data line and a framing line. A host issues one request at a time over a valid/ready handshake: a register read, a register write, or a long write that streams a run of configuration words into a peripheral. The master serialises the request onto the link that the host selects, and then waits for the peripheral to answer on a separate return line.

Every request, the long bursts included, ends only when the addressed slave has acknowledged it. If the return line stays silent for too long, the master does not retry. It holds the link quiet for a fixed number of serial clocks so that the far end resynchronises, and then reports a timeout. Each request ends with one single-cycle completion pulse that carries a status and, for reads, the returned data. Slave endpoints with a small register file are built into the block on the first link ports, so the master and slave can be verified as a pair. The remaining ports are left open and never answer.

Top module: `ctl_star_link`

## Requirements
- R1: After reset, req_ready is 1, done is 0, and every link_frame and link_mosi bit is 0.
- R2: link_sclk runs continuously at the clock frequency divided by CLK_DIV (default 4), high for half of each period.
- R3: A read or write frame holds link_frame of the selected port high for exactly 26 serial clocks and sends {opcode[1:0], address[7:0], data[15:0]} MSB first, one bit per serial clock. The opcode is 00 for read, 01 for write, 10 for long write and 11 reserved. link_mosi changes only while link_sclk is low, and the slave's return line stays low while frame is high.
- R4: A write followed by a read of the same in-range address returns the written value with status 00 (ok). done is high for exactly one clock per request.
- R5: Only the selected port's frame line is ever driven, and a request to one slave leaves the registers of the other slaves unchanged.
- R6: An address at or above SLV_REGS (16 by default), or the reserved opcode 11, completes with status 01 (error).
- R7: A long write sends the 26-bit header, then a 16-bit word count N, then N 16-bit words, with frame held high for all 42+16N bits. burst_take pulses once per word consumed. The header data goes to the header address, and word i goes to address+1+i modulo SLV_REGS. It completes with status 00.
- R8: A long write with a word count of 0 writes only the header data, consumes no burst word, and holds frame for exactly 42 bits.
- R9: A request to a port that never answers completes with status 10 (timeout). This happens after TIMEOUT serial clocks of waiting and then RESET_LEN serial clocks with frame and data low. A later request to a live port completes normally.
- R10: req_ready is 0 while a request is in progress, and a request presented then has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Master idle, request accepted when valid |
| req_op | input | 2 | Opcode: 00 read, 01 write, 10 long write, 11 reserved |
| req_port | input | PW (2) | Link port to address |
| req_addr | input | 8 | Register address |
| req_wdata | input | 16 | Write data, or first word of a long write |
| req_count | input | 16 | Number of burst words for a long write |
| burst_data | input | 16 | Next burst word, held until burst_take |
| burst_take | output | 1 | One-cycle pulse after a burst word is consumed |
| done | output | 1 | One-cycle completion pulse |
| done_status | output | 2 | 00 ok, 01 error, 10 timeout |
| done_rdata | output | 16 | Read data, valid with done on an ok read |
| link_sclk | output | 1 | Serial clock shared by all links |
| link_frame | output | NUM_PORTS (3) | Frame line per port |
| link_mosi | output | NUM_PORTS (3) | Outbound data line per port |

## Verification
The assertions assume that the host raises req_valid only while req_ready is high or while it is deliberately probing the busy period. They also assume that burst_data always holds the next word before the fall of the serial clock that consumes it. The bench respects both: it issues each request only after the previous completion pulse, and it advances its burst word index on the burst_take pulse, sixteen serial clocks before the next word is needed. CLK_DIV is kept even and at least 4, so the slave's one-clock edge detection still lands its reply before the master samples it.

// File: rtl/csl_pkg.sv
package csl_pkg;
    localparam logic [1:0] OP_RD  = 2'b00;
    localparam logic [1:0] OP_WR  = 2'b01;
    localparam logic [1:0] OP_LW  = 2'b10;
    localparam logic [1:0] OP_RSV = 2'b11;

    localparam logic [7:0] ACK_OK  = 8'hA5;
    localparam logic [7:0] ACK_ERR = 8'h5A;

    localparam logic [1:0] ST_OK  = 2'b00;
    localparam logic [1:0] ST_ERR = 2'b01;
    localparam logic [1:0] ST_TO  = 2'b10;

    localparam int HDR_BITS = 26;
    localparam int LW_BITS  = 42;
endpackage

// File: rtl/csl_slave.sv
module csl_slave
    import csl_pkg::*;
#(
    parameter int REGS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic frame,
    input  logic mosi,
    output logic miso
);
    localparam int AW = $clog2(REGS);

    typedef enum logic [1:0] {S_IDLE, S_RX, S_RESP} sst_e;

    typedef struct packed {
        sst_e          st;
        logic          sclk_p;
        logic [5:0]    n;
        logic          bad;
        logic [1:0]    op;
        logic [7:0]    addr;
        logic [15:0]   data;
        logic [15:0]   sh;
        logic [3:0]    bidx;
        logic [15:0]   left;
        logic [AW-1:0] wptr;
        logic [24:0]   rsh;
        logic [4:0]    rlen;
        logic          miso;
    } sst_t;

    sst_t q, d;
    logic [15:0] regs_q [REGS];
    logic          we;
    logic [AW-1:0] waddr;
    logic [15:0]   wdata;
    logic rise, fall, in_range, good, ok;
    logic [15:0] shn;

    always_comb begin
        d = q;
        we = 1'b0;
        waddr = '0;
        wdata = '0;
        d.sclk_p = sclk;
        rise = sclk && !q.sclk_p;
        fall = !sclk && q.sclk_p;
        in_range = (32'(q.addr) < REGS);
        shn = {q.sh[14:0], mosi};
        good = !q.bad && ((q.op != OP_LW && q.n == 6'(HDR_BITS)) ||
               (q.op == OP_LW && q.n == 6'(LW_BITS) && q.bidx == 4'd0 && q.left == 16'd0));
        ok = in_range && (q.op != OP_RSV);
        if (rise) begin
            case (q.st)
                S_IDLE: if (frame) begin
                    d.st = S_RX;
                    d.sh = shn;
                    d.n = 6'd1;
                    d.bad = 1'b0;
                    d.bidx = 4'd0;
                    d.left = 16'd0;
                end
                S_RX: if (frame) begin
                    d.sh = shn;
                    if (q.n != 6'(LW_BITS)) d.n = q.n + 6'd1;
                    if (q.n == 6'd1) d.op = shn[1:0];
                    if (q.n == 6'd9) d.addr = shn[7:0];
                    if (q.n == 6'd25) begin
                        d.data = shn;
                        if (q.op == OP_LW && in_range) begin
                            we = 1'b1;
                            waddr = q.addr[AW-1:0];
                            wdata = shn;
                        end
                    end
                    if (q.n == 6'(HDR_BITS) && q.op != OP_LW) d.bad = 1'b1;
                    if (q.n == 6'd41) begin
                        d.left = shn;
                        d.wptr = q.addr[AW-1:0] + AW'(1);
                    end
                    if (q.n == 6'(LW_BITS)) begin
                        d.bidx = q.bidx + 4'd1;
                        if (q.bidx == 4'd15) begin
                            if (q.left == 16'd0) d.bad = 1'b1;
                            else begin
                                d.left = q.left - 16'd1;
                                d.wptr = q.wptr + AW'(1);
                                if (in_range) begin
                                    we = 1'b1;
                                    waddr = q.wptr;
                                    wdata = shn;
                                end
                            end
                        end
                    end
                end else if (!good) begin
                    d.st = S_IDLE;
                end else begin
                    if (q.op == OP_WR && ok) begin
                        we = 1'b1;
                        waddr = q.addr[AW-1:0];
                        wdata = q.data;
                    end
                    d.rsh = {1'b1, ok ? ACK_OK : ACK_ERR,
                             (q.op == OP_RD && ok) ? regs_q[q.addr[AW-1:0]] : 16'h0};
                    d.rlen = (q.op == OP_RD) ? 5'd25 : 5'd9;
                    d.st = S_RESP;
                end
                default: ;
            endcase
        end
        if (fall && q.st == S_RESP) begin
            if (q.rlen != 5'd0) begin
                d.miso = q.rsh[24];
                d.rsh = {q.rsh[23:0], 1'b0};
                d.rlen = q.rlen - 5'd1;
            end else begin
                d.miso = 1'b0;
                d.st = S_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < REGS; i++) regs_q[i] <= 16'h0;
        end else if (we) begin
            regs_q[waddr] <= wdata;
        end
    end

    assign miso = q.miso;

    // R3
    resp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame && $past(frame)) |-> !miso);
endmodule

// File: rtl/csl_master.sv
module csl_master
    import csl_pkg::*;
#(
    parameter int NUM_PORTS = 3,
    parameter int CLK_DIV   = 4,
    parameter int TIMEOUT   = 256,
    parameter int RESET_LEN = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic [1:0]                   req_op,
    input  logic [$clog2(NUM_PORTS)-1:0] req_port,
    input  logic [7:0]                   req_addr,
    input  logic [15:0]                  req_wdata,
    input  logic [15:0]                  req_count,
    input  logic [15:0]                  burst_data,
    output logic                         burst_take,
    output logic                         done,
    output logic [1:0]                   done_status,
    output logic [15:0]                  done_rdata,
    output logic                         link_sclk,
    output logic [NUM_PORTS-1:0]         link_frame,
    output logic [NUM_PORTS-1:0]         link_mosi,
    input  logic [NUM_PORTS-1:0]         link_miso
);
    localparam int PW   = $clog2(NUM_PORTS);
    localparam int DW   = $clog2(CLK_DIV);
    localparam int HALF = CLK_DIV / 2;
    localparam int TMAX = (TIMEOUT > RESET_LEN) ? TIMEOUT : RESET_LEN;
    localparam int TW   = $clog2(TMAX + 1);

    typedef enum logic [2:0] {M_IDLE, M_SEND, M_WAIT, M_RECV, M_LRST} mst_e;

    typedef struct packed {
        mst_e        st;
        logic [DW-1:0] div;
        logic [PW-1:0] port;
        logic        is_rd;
        logic [41:0] shreg;
        logic [5:0]  bits;
        logic [15:0] words;
        logic        frame;
        logic        mosi;
        logic [TW-1:0] tcnt;
        logic [4:0]  rxbits;
        logic [23:0] rxsh;
        logic        done;
        logic [1:0]  status;
        logic [15:0] rdata;
        logic        take;
    } mst_t;

    mst_t q, d;
    logic rise, fall, miso_sel;
    logic [7:0] ack;

    always_comb begin
        miso_sel = 1'b0;
        for (int p = 0; p < NUM_PORTS; p++)
            if (q.port == PW'(p)) miso_sel = link_miso[p];
    end

    always_comb begin
        d = q;
        d.done = 1'b0;
        d.take = 1'b0;
        ack = 8'h0;
        rise = (q.div == DW'(HALF - 1));
        fall = (q.div == DW'(CLK_DIV - 1));
        d.div = fall ? '0 : q.div + DW'(1);
        case (q.st)
            M_IDLE: if (req_valid) begin
                d.port = req_port;
                d.is_rd = (req_op == OP_RD);
                if (req_op == OP_LW) begin
                    d.shreg = {req_op, req_addr, req_wdata, req_count};
                    d.bits = 6'(LW_BITS);
                    d.words = req_count;
                end else begin
                    d.shreg = {req_op, req_addr, req_wdata, 16'h0};
                    d.bits = 6'(HDR_BITS);
                    d.words = 16'd0;
                end
                d.st = M_SEND;
            end
            M_SEND: if (fall) begin
                if (q.bits != 6'd0) begin
                    d.frame = 1'b1;
                    d.mosi = q.shreg[41];
                    d.shreg = {q.shreg[40:0], 1'b0};
                    d.bits = q.bits - 6'd1;
                end else if (q.words != 16'd0) begin
                    d.frame = 1'b1;
                    d.mosi = burst_data[15];
                    d.shreg = {burst_data[14:0], 27'h0};
                    d.bits = 6'd15;
                    d.words = q.words - 16'd1;
                    d.take = 1'b1;
                end else begin
                    d.frame = 1'b0;
                    d.mosi = 1'b0;
                    d.tcnt = '0;
                    d.st = M_WAIT;
                end
            end
            M_WAIT: if (rise) begin
                if (miso_sel) begin
                    d.rxbits = q.is_rd ? 5'd24 : 5'd8;
                    d.st = M_RECV;
                end else if (q.tcnt == TW'(TIMEOUT - 1)) begin
                    d.tcnt = '0;
                    d.st = M_LRST;
                end else begin
                    d.tcnt = q.tcnt + TW'(1);
                end
            end
            M_RECV: if (rise) begin
                d.rxsh = {q.rxsh[22:0], miso_sel};
                d.rxbits = q.rxbits - 5'd1;
                if (q.rxbits == 5'd1) begin
                    ack = q.is_rd ? d.rxsh[23:16] : d.rxsh[7:0];
                    d.status = (ack == ACK_OK) ? ST_OK : ST_ERR;
                    d.rdata = q.is_rd ? d.rxsh[15:0] : 16'h0;
                    d.done = 1'b1;
                    d.st = M_IDLE;
                end
            end
            M_LRST: if (rise) begin
                if (q.tcnt == TW'(RESET_LEN - 1)) begin
                    d.status = ST_TO;
                    d.rdata = 16'h0;
                    d.done = 1'b1;
                    d.st = M_IDLE;
                end else begin
                    d.tcnt = q.tcnt + TW'(1);
                end
            end
            default: d.st = M_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        for (int p = 0; p < NUM_PORTS; p++) begin
            link_frame[p] = q.frame && (q.port == PW'(p));
            link_mosi[p]  = q.mosi && (q.port == PW'(p));
        end
    end

    assign req_ready   = (q.st == M_IDLE);
    assign link_sclk   = (q.div >= DW'(HALF));
    assign done        = q.done;
    assign done_status = q.status;
    assign done_rdata  = q.rdata;
    assign burst_take  = q.take;

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R5
    port_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(link_frame));
    // R10
    idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (link_frame == '0));
    // R9
    quiet_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_status == ST_TO) |-> ($past(link_frame) == '0 && $past(link_mosi) == '0));
    // R7
    take_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        burst_take |-> (link_frame != '0));
endmodule

// File: rtl/ctl_star_link.sv
module ctl_star_link
    import csl_pkg::*;
#(
    parameter int NUM_PORTS  = 3,
    parameter int NUM_SLAVES = 2,
    parameter int CLK_DIV    = 4,
    parameter int TIMEOUT    = 256,
    parameter int RESET_LEN  = 32,
    parameter int SLV_REGS   = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic [1:0]                   req_op,
    input  logic [$clog2(NUM_PORTS)-1:0] req_port,
    input  logic [7:0]                   req_addr,
    input  logic [15:0]                  req_wdata,
    input  logic [15:0]                  req_count,
    input  logic [15:0]                  burst_data,
    output logic                         burst_take,
    output logic                         done,
    output logic [1:0]                   done_status,
    output logic [15:0]                  done_rdata,
    output logic                         link_sclk,
    output logic [NUM_PORTS-1:0]         link_frame,
    output logic [NUM_PORTS-1:0]         link_mosi
);
    logic [NUM_PORTS-1:0] miso_w;

    csl_master #(
        .NUM_PORTS(NUM_PORTS), .CLK_DIV(CLK_DIV),
        .TIMEOUT(TIMEOUT), .RESET_LEN(RESET_LEN)
    ) u_master (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_port(req_port), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_count(req_count), .burst_data(burst_data), .burst_take(burst_take),
        .done(done), .done_status(done_status), .done_rdata(done_rdata),
        .link_sclk(link_sclk), .link_frame(link_frame), .link_mosi(link_mosi),
        .link_miso(miso_w)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        if (p < NUM_SLAVES) begin : g_slave
            csl_slave #(.REGS(SLV_REGS)) u_slave (
                .clk(clk), .rst_n(rst_n), .sclk(link_sclk),
                .frame(link_frame[p]), .mosi(link_mosi[p]), .miso(miso_w[p])
            );
        end else begin : g_open
            assign miso_w[p] = 1'b0;
        end
    end
endmodule

// File: tb/sim_ctl_star_link.sv
`timescale 1ns/1ps
module sim_ctl_star_link;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [1:0] req_op = 2'b00;
    logic [1:0] req_port = 2'd0;
    logic [7:0] req_addr = 8'h0;
    logic [15:0] req_wdata = 16'h0;
    logic [15:0] req_count = 16'h0;
    logic [15:0] burst_data;
    logic burst_take, done, link_sclk;
    logic [1:0] done_status;
    logic [15:0] done_rdata;
    logic [2:0] link_frame, link_mosi;

    int tests = 0, fails = 0;
    logic [15:0] lw_words [8];
    int bidx = 0, takes = 0;
    int mon_port = 0;
    logic [127:0] mon_bits = '0;
    int mon_n = 0, mosi_bad = 0, idle_bad = 0;
    int rises [3] = '{0, 0, 0};
    logic sprev = 1'b0, mprev = 1'b0;
    logic [2:0] fprev = 3'b0;

    always #4 clk = ~clk;

    assign burst_data = lw_words[bidx % 8];

    ctl_star_link u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_port(req_port), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_count(req_count), .burst_data(burst_data),
        .burst_take(burst_take), .done(done), .done_status(done_status),
        .done_rdata(done_rdata), .link_sclk(link_sclk), .link_frame(link_frame),
        .link_mosi(link_mosi)
    );

    always @(negedge clk) begin
        for (int p = 0; p < 3; p++)
            if (link_frame[p] && !fprev[p]) rises[p]++;
        if (link_sclk && !sprev && link_frame[mon_port]) begin
            mon_bits = {mon_bits[126:0], link_mosi[mon_port]};
            mon_n++;
        end
        if (link_sclk && sprev && link_mosi[mon_port] != mprev) mosi_bad++;
        if (!link_frame[mon_port] && link_mosi[mon_port]) idle_bad++;
        if (burst_take) begin
            takes++;
            bidx++;
        end
        sprev = link_sclk;
        mprev = link_mosi[mon_port];
        fprev = link_frame;
    end

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_req(input logic [1:0] op, input int port, input logic [7:0] addr,
                          input logic [15:0] data, input logic [15:0] cnt,
                          output logic [1:0] st, output logic [15:0] rd, output int cyc);
        @(negedge clk);
        mon_port = port;
        req_op = op;
        req_port = port[1:0];
        req_addr = addr;
        req_wdata = data;
        req_count = cnt;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1;
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        st = done_status;
        rd = done_rdata;
        @(negedge clk);
        chk("R4 done width", {127'h0, done}, 128'h0);
        repeat (8) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 ready", {127'h0, req_ready}, 128'h1);
        chk("R1 done", {127'h0, done}, 128'h0);
        chk("R1 link", {122'h0, link_frame, link_mosi}, 128'h0);
    endtask

    task automatic t_sclk();
        int hi = 0, re = 0;
        logic pv;
        @(negedge clk);
        pv = link_sclk;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (link_sclk) hi++;
            if (link_sclk && !pv) re++;
            pv = link_sclk;
        end
        chk("R2 high count", 128'(hi), 128'd20);
        chk("R2 period", 128'(re), 128'd10);
    endtask

    task automatic t_wr_rd();
        logic [1:0] st; logic [15:0] rd; int cyc, n0, r0, mb0;
        n0 = mon_n; r0 = rises[0]; mb0 = mosi_bad;
        do_req(2'b01, 0, 8'h03, 16'h1234, 16'h0, st, rd, cyc);
        chk("R3 bit count", 128'(mon_n - n0), 128'd26);
        chk("R3 frame bits", 128'(mon_bits[25:0]), {102'h0, 2'b01, 8'h03, 16'h1234});
        chk("R3 single frame", 128'(rises[0] - r0), 128'd1);
        chk("R3 mosi on low sclk", 128'(mosi_bad - mb0), 128'd0);
        chk("R4 write status", 128'(st), 128'd0);
        do_req(2'b00, 0, 8'h03, 16'h0, 16'h0, st, rd, cyc);
        chk("R3 read frame", 128'(mon_bits[25:0]), {102'h0, 2'b00, 8'h03, 16'h0});
        chk("R4 read status", 128'(st), 128'd0);
        chk("R4 read data", 128'(rd), 128'h1234);
    endtask

    task automatic t_iso();
        logic [1:0] st; logic [15:0] rd; int cyc, r0, r2;
        r0 = rises[0]; r2 = rises[2];
        do_req(2'b01, 1, 8'h03, 16'hBEEF, 16'h0, st, rd, cyc);
        chk("R5 other ports quiet", 128'((rises[0] - r0) + (rises[2] - r2)), 128'd0);
        do_req(2'b00, 0, 8'h03, 16'h0, 16'h0, st, rd, cyc);
        chk("R5 port0 untouched", 128'(rd), 128'h1234);
        do_req(2'b00, 1, 8'h03, 16'h0, 16'h0, st, rd, cyc);
        chk("R5 port1 value", 128'(rd), 128'hBEEF);
    endtask

    task automatic t_err();
        logic [1:0] st; logic [15:0] rd; int cyc;
        do_req(2'b00, 0, 8'h20, 16'h0, 16'h0, st, rd, cyc);
        chk("R6 address range", 128'(st), 128'd1);
        do_req(2'b11, 0, 8'h01, 16'h0, 16'h0, st, rd, cyc);
        chk("R6 reserved opcode", 128'(st), 128'd1);
    endtask

    task automatic t_lw();
        logic [1:0] st; logic [15:0] rd; int cyc, n0, t0, r0;
        for (int i = 0; i < 8; i++) lw_words[i] = 16'hA000 + 16'(i);
        @(negedge clk);
        bidx = 0;
        n0 = mon_n; t0 = takes; r0 = rises[0];
        do_req(2'b10, 0, 8'h0E, 16'h1111, 16'd4, st, rd, cyc);
        chk("R7 status", 128'(st), 128'd0);
        chk("R7 bit count", 128'(mon_n - n0), 128'd106);
        chk("R7 single frame", 128'(rises[0] - r0), 128'd1);
        chk("R7 takes", 128'(takes - t0), 128'd4);
        chk("R7 last word on wire", 128'(mon_bits[15:0]), 128'hA003);
        do_req(2'b00, 0, 8'h0E, 16'h0, 16'h0, st, rd, cyc);
        chk("R7 header word", 128'(rd), 128'h1111);
        do_req(2'b00, 0, 8'h0F, 16'h0, 16'h0, st, rd, cyc);
        chk("R7 word0", 128'(rd), 128'hA000);
        do_req(2'b00, 0, 8'h00, 16'h0, 16'h0, st, rd, cyc);
        chk("R7 wrap word1", 128'(rd), 128'hA001);
        do_req(2'b00, 0, 8'h02, 16'h0, 16'h0, st, rd, cyc);
        chk("R7 word3", 128'(rd), 128'hA003);
    endtask

    task automatic t_lw0();
        logic [1:0] st; logic [15:0] rd; int cyc, n0, t0;
        n0 = mon_n; t0 = takes;
        do_req(2'b10, 1, 8'h07, 16'h7777, 16'd0, st, rd, cyc);
        chk("R8 status", 128'(st), 128'd0);
        chk("R8 bit count", 128'(mon_n - n0), 128'd42);
        chk("R8 no takes", 128'(takes - t0), 128'd0);
        do_req(2'b00, 1, 8'h07, 16'h0, 16'h0, st, rd, cyc);
        chk("R8 header word", 128'(rd), 128'h7777);
        do_req(2'b00, 1, 8'h08, 16'h0, 16'h0, st, rd, cyc);
        chk("R8 next untouched", 128'(rd), 128'h0);
    endtask

    task automatic t_timeout();
        logic [1:0] st; logic [15:0] rd; int cyc, r2, ib0;
        r2 = rises[2]; ib0 = idle_bad;
        do_req(2'b01, 2, 8'h01, 16'h5555, 16'h0, st, rd, cyc);
        chk("R9 status", 128'(st), 128'd2);
        chk("R9 window", 128'((cyc >= 1240) && (cyc <= 1280)), 128'd1);
        chk("R9 quiet link", 128'((rises[2] - r2 == 1) && (idle_bad == ib0)), 128'd1);
        do_req(2'b00, 0, 8'h03, 16'h0, 16'h0, st, rd, cyc);
        chk("R9 recovery status", 128'(st), 128'd0);
        chk("R9 recovery data", 128'(rd), 128'h1234);
    endtask

    task automatic t_busy();
        logic [1:0] st; logic [15:0] rd; int cyc, rdy;
        @(negedge clk);
        mon_port = 1;
        req_op = 2'b00; req_port = 2'd1; req_addr = 8'h03;
        req_wdata = 16'h0; req_count = 16'h0;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (10) @(negedge clk);
        req_op = 2'b01; req_port = 2'd0; req_addr = 8'h05; req_wdata = 16'hDEAD;
        req_valid = 1'b1;
        rdy = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (req_ready) rdy++;
        end
        req_valid = 1'b0;
        chk("R10 ready low", 128'(rdy), 128'd0);
        cyc = 0;
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        chk("R10 first request data", 128'(done_rdata), 128'hBEEF);
        repeat (8) @(negedge clk);
        do_req(2'b00, 0, 8'h05, 16'h0, 16'h0, st, rd, cyc);
        chk("R10 busy request ignored", 128'(rd), 128'h0);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) lw_words[i] = 16'h0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_sclk();
        t_wr_rd();
        t_iso();
        t_err();
        t_lw();
        t_lw0();
        t_timeout();
        t_busy();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(200000 * 8);
        tests++;
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule